// File: doc/BRIEF.md
# Stride-Confirming Data Prefetch Predictor

This block watches the stream of load and store references leaving a processor core. Each reference carries the address of the instruction that made it and the data address it touched. A small direct-mapped table, indexed by the low bits of the instruction address, remembers for each instruction the last data address it used, the distance between its last two addresses, and a four-state confidence machine. When an instruction's stride has been confirmed often enough, the block predicts the next address (current address plus stride) and places it in a short ordered queue of pending prefetches.

The queue presents its oldest address to a single memory port. It gives way to demand misses: while the cache reports a demand miss in progress, no prefetch is offered. A translation check on the head address can flag it as faulting, and a faulting head is thrown away instead of being issued. The cache and the address translation logic sit outside this block.

Top module: `rpt_prefetcher`

## Requirements
- R1: After reset the queue is empty (pf_valid low) and every table entry is invalid, so the first reference from any instruction allocates.
- R2: A reference whose instruction address is not in the table (the entry at index ref_pc[IDX_W-1:0] is invalid or holds another instruction address) overwrites that entry with state initial, stride zero and last address ref_addr, and queues no prefetch.
- R3: On a table hit the reference is correct when ref_addr minus the stored last address (modulo 2^ADDR_W) equals the stored stride; the state moves initial->steady, transient->steady, steady->steady, no-prediction->transient when correct, and initial->transient, transient->no-prediction, steady->initial, no-prediction->no-prediction when incorrect.
- R4: On a hit the last address always becomes ref_addr; the stride becomes the new difference on an incorrect reference, except when the old state was steady, where the stride is kept; a correct reference keeps the stride.
- R5: On a hit whose new state is not no-prediction, the address ref_addr plus the updated stride (modulo 2^ADDR_W) is queued at the clock edge that takes the reference, so it can reach pf_addr in the following cycle; a no-prediction result queues nothing.
- R6: Queued addresses leave in arrival order; pf_addr shows the oldest one, and it stays there until a cycle with pf_valid and pf_ready both high removes it.
- R7: While miss_busy is high pf_valid is low and nothing leaves the queue.
- R8: When pf_fault is high and the queue is not empty, pf_valid is low and the oldest address is removed at that clock edge without being issued.
- R9: A new prefetch is discarded when the queue already holds DEPTH addresses, or when the same address is already held in the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_valid | input | 1 | A memory reference is presented this cycle |
| ref_pc | input | PC_W | Instruction address of the reference |
| ref_addr | input | ADDR_W | Data address of the reference |
| miss_busy | input | 1 | A demand miss owns the memory port |
| pf_fault | input | 1 | The address on pf_addr would raise an exception |
| pf_ready | input | 1 | Memory port accepts the offered prefetch |
| pf_valid | output | 1 | A prefetch is offered on pf_addr |
| pf_addr | output | ADDR_W | Oldest queued prefetch address |

## Verification
A reference is taken at one rising edge and its prefetch, if any, sits in the queue right after that edge, so the bench drives references at the falling edge and looks at pf_valid and pf_addr one falling edge later. The effects of miss_busy and pf_fault on pf_valid are combinational and are sampled shortly after those inputs change, while a removal shows up only after the next rising edge. A bench model of the table and queue, written from the requirements, supplies the expected head address for each sample, and the queue is drained after every reference in the long sweep so that each prediction is compared on its own.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

  typedef enum logic [1:0] {
    ST_INIT   = 2'd0,
    ST_TRANS  = 2'd1,
    ST_STEADY = 2'd2,
    ST_NOPRED = 2'd3
  } rpt_state_e;

endpackage

// File: rtl/rpt_fsm.sv
module rpt_fsm
  import rpt_pkg::*;
(
  input  rpt_state_e cur_state,
  input  logic       stride_match,
  output rpt_state_e nxt_state,
  output logic       relearn
);

  always_comb begin
    nxt_state = cur_state;
    relearn   = 1'b0;
    unique case (cur_state)
      ST_INIT: begin
        nxt_state = stride_match ? ST_STEADY : ST_TRANS;
        relearn   = !stride_match;
      end
      ST_TRANS: begin
        nxt_state = stride_match ? ST_STEADY : ST_NOPRED;
        relearn   = !stride_match;
      end
      ST_STEADY: begin
        nxt_state = stride_match ? ST_STEADY : ST_INIT;
        relearn   = 1'b0;
      end
      ST_NOPRED: begin
        nxt_state = stride_match ? ST_TRANS : ST_NOPRED;
        relearn   = !stride_match;
      end
      default: begin
        nxt_state = ST_NOPRED;
        relearn   = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/rpt_table.sv
module rpt_table
  import rpt_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_valid,
  input  logic [PC_W-1:0]   ref_pc,
  input  logic [ADDR_W-1:0] ref_addr,
  output logic              cand_valid,
  output logic [ADDR_W-1:0] cand_addr
);

  localparam int ENTRIES = 1 << IDX_W;

  logic              ent_vld    [ENTRIES];
  logic [PC_W-1:0]   ent_pc     [ENTRIES];
  logic [ADDR_W-1:0] ent_prev   [ENTRIES];
  logic [ADDR_W-1:0] ent_stride [ENTRIES];
  rpt_state_e        ent_state  [ENTRIES];

  logic [IDX_W-1:0]  idx;
  logic              hit;
  logic [ADDR_W-1:0] delta;
  logic              match;
  rpt_state_e        fsm_nxt;
  logic              fsm_relearn;

  rpt_state_e        upd_state;
  logic [ADDR_W-1:0] upd_stride;

  // lookup
  always_comb begin
    idx   = ref_pc[IDX_W-1:0];
    hit   = ent_vld[idx] && (ent_pc[idx] == ref_pc);
    delta = ref_addr - ent_prev[idx];
    match = (delta == ent_stride[idx]);
  end

  rpt_fsm u_fsm (
    .cur_state    (ent_state[idx]),
    .stride_match (match),
    .nxt_state    (fsm_nxt),
    .relearn      (fsm_relearn)
  );

  // next entry contents
  always_comb begin
    if (hit) begin
      upd_state  = fsm_nxt;
      upd_stride = fsm_relearn ? delta : ent_stride[idx];
    end else begin
      upd_state  = ST_INIT;
      upd_stride = '0;
    end
    cand_valid = ref_valid && hit && (fsm_nxt != ST_NOPRED);
    cand_addr  = ref_addr + upd_stride;
  end

  // entry registers
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic wr_en;
    assign wr_en = ref_valid && (idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_vld[g]    <= 1'b0;
        ent_pc[g]     <= '0;
        ent_prev[g]   <= '0;
        ent_stride[g] <= '0;
        ent_state[g]  <= ST_INIT;
      end else if (wr_en) begin
        ent_vld[g]    <= 1'b1;
        ent_pc[g]     <= ref_pc;
        ent_prev[g]   <= ref_addr;
        ent_stride[g] <= upd_stride;
        ent_state[g]  <= upd_state;
      end
    end
  end

  // R2: a miss leaves the entry in the initial state with a zero stride
  a_r2_alloc_init : assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && !hit) |=> (ent_state[$past(idx)] == ST_INIT &&
                             ent_stride[$past(idx)] == '0));

  // R3: a confirmed stride keeps a steady entry steady
  a_r3_steady_holds : assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && hit && match && ent_state[idx] == ST_STEADY)
      |=> ent_state[$past(idx)] == ST_STEADY);

  // R4: the stored last address follows every reference
  a_r4_prev_tracks : assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> ent_prev[$past(idx)] == $past(ref_addr));

endmodule

// File: rtl/rpt_reqlist.sv
module rpt_reqlist #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              miss_busy,
  input  logic              fault,
  input  logic              pf_ready,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;

  logic [ADDR_W-1:0] slot [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, rd_ptr_n;
  logic [PTR_W-1:0]  wr_ptr, wr_ptr_n;
  logic [CNT_W-1:0]  count, count_n;

  logic [DEPTH-1:0]  same;
  logic              empty, full, dup;
  logic              push, pop, drop;

  // duplicate search over occupied slots
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic [PTR_W-1:0] age;
    assign age     = PTR_W'(g) - rd_ptr;
    assign same[g] = ({1'b0, age} < count) && (slot[g] == push_addr);
  end

  always_comb begin
    empty    = (count == '0);
    full     = (count == CNT_W'(DEPTH));
    dup      = |same;
    pf_valid = !empty && !miss_busy && !fault;
    pf_addr  = slot[rd_ptr];
    drop     = !empty && fault;
    pop      = (pf_valid && pf_ready) || drop;
    push     = push_valid && !full && !dup;

    rd_ptr_n = pop  ? rd_ptr + PTR_W'(1) : rd_ptr;
    wr_ptr_n = push ? wr_ptr + PTR_W'(1) : wr_ptr;
    count_n  = count + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      rd_ptr <= rd_ptr_n;
      wr_ptr <= wr_ptr_n;
      count  <= count_n;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot[g] <= '0;
      end else if (push && (wr_ptr == PTR_W'(g))) begin
        slot[g] <= push_addr;
      end
    end
  end

  // R9: occupancy never passes the queue depth
  a_r9_count_bound : assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R9: an accepted entry without a removal grows the queue by one
  a_r9_push_grows : assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> count == $past(count) + CNT_W'(1));

  // R6: a stalled offer keeps its address
  a_r6_head_hold : assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> $stable(pf_addr));

endmodule

// File: rtl/rpt_prefetcher.sv
module rpt_prefetcher #(
  parameter int PC_W   = 16,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 2,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_valid,
  input  logic [PC_W-1:0]   ref_pc,
  input  logic [ADDR_W-1:0] ref_addr,
  input  logic              miss_busy,
  input  logic              pf_fault,
  input  logic              pf_ready,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);

  logic              cand_valid;
  logic [ADDR_W-1:0] cand_addr;

  rpt_table #(
    .PC_W   (PC_W),
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
  ) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_valid  (ref_valid),
    .ref_pc     (ref_pc),
    .ref_addr   (ref_addr),
    .cand_valid (cand_valid),
    .cand_addr  (cand_addr)
  );

  rpt_reqlist #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH)
  ) u_list (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (cand_valid),
    .push_addr  (cand_addr),
    .miss_busy  (miss_busy),
    .fault      (pf_fault),
    .pf_ready   (pf_ready),
    .pf_valid   (pf_valid),
    .pf_addr    (pf_addr)
  );

  // R7: the memory port is never offered a prefetch during a demand miss
  a_r7_busy_blocks : assert property (@(posedge clk) disable iff (!rst_n)
    miss_busy |-> !pf_valid);

endmodule

// File: tb/sim_rpt_prefetcher.sv
module sim_rpt_prefetcher;

  localparam int PC_W = 16, ADDR_W = 16, IDX_W = 2, DEPTH = 4;
  localparam int ENT = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_valid = 1'b0;
  logic [PC_W-1:0] ref_pc = '0;
  logic [ADDR_W-1:0] ref_addr = '0;
  logic miss_busy = 1'b0, pf_fault = 1'b0, pf_ready = 1'b0;
  logic pf_valid;
  logic [ADDR_W-1:0] pf_addr;

  always #5 clk = ~clk;

  rpt_prefetcher #(.PC_W(PC_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_pc(ref_pc),
    .ref_addr(ref_addr), .miss_busy(miss_busy), .pf_fault(pf_fault),
    .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr));

  int total = 0, failed = 0;
  bit reported = 0;

  // model: state 0 initial, 1 transient, 2 steady, 3 no-prediction
  bit              mv   [ENT];
  logic [PC_W-1:0] mpc  [ENT];
  logic [ADDR_W-1:0] mprev [ENT];
  logic [ADDR_W-1:0] mstr  [ENT];
  int              mst  [ENT];
  logic [ADDR_W-1:0] mq[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", total - failed, total);
    end
  endtask

  function automatic void model_ref(logic [PC_W-1:0] pc, logic [ADDR_W-1:0] a);
    int i = int'(pc[IDX_W-1:0]);
    if (mv[i] && mpc[i] == pc) begin
      logic [ADDR_W-1:0] d = a - mprev[i];
      bit ok = (d == mstr[i]);
      int ns;
      case (mst[i])
        0: begin ns = ok ? 2 : 1; if (!ok) mstr[i] = d; end
        1: begin ns = ok ? 2 : 3; if (!ok) mstr[i] = d; end
        2: ns = ok ? 2 : 0;
        default: begin ns = ok ? 1 : 3; if (!ok) mstr[i] = d; end
      endcase
      mst[i] = ns;
      mprev[i] = a;
      if (ns != 3) begin
        logic [ADDR_W-1:0] p = a + mstr[i];
        bit found = 0;
        foreach (mq[k]) if (mq[k] == p) found = 1;
        if (!found && mq.size() < DEPTH) mq.push_back(p);
      end
    end else begin
      mv[i] = 1; mpc[i] = pc; mprev[i] = a; mstr[i] = '0; mst[i] = 0;
    end
  endfunction

  // reference at one edge, head sampled at the next falling edge
  task automatic do_ref(string req, logic [PC_W-1:0] pc, logic [ADDR_W-1:0] a);
    @(negedge clk);
    pf_ready = 1'b0; miss_busy = 1'b0; pf_fault = 1'b0;
    ref_valid = 1'b1; ref_pc = pc; ref_addr = a;
    @(posedge clk);
    model_ref(pc, a);
    @(negedge clk);
    ref_valid = 1'b0;
    #1;
    check({req, " valid"}, 32'(pf_valid), 32'(mq.size() > 0));
    if (mq.size() > 0) check({req, " head"}, 32'(pf_addr), 32'(mq[0]));
  endtask

  task automatic drain(string req);
    while (mq.size() > 0) begin
      @(negedge clk);
      pf_ready = 1'b1; miss_busy = 1'b0; pf_fault = 1'b0;
      #1;
      check({req, " drain valid"}, 32'(pf_valid), 32'd1);
      check({req, " drain addr"}, 32'(pf_addr), 32'(mq[0]));
      @(posedge clk);
      void'(mq.pop_front());
    end
    @(negedge clk);
    pf_ready = 1'b0;
    #1;
    check({req, " empty after drain"}, 32'(pf_valid), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] last [6];
    logic [ADDR_W-1:0] strd [6];
    logic [PC_W-1:0] pcs [6];
    logic [31:0] lcg = 32'h1234_5678;

    for (int i = 0; i < ENT; i++) begin mv[i] = 0; mst[i] = 0; mstr[i] = '0; mprev[i] = '0; mpc[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1 reset valid", 32'(pf_valid), 32'd0);

    // R2: first touch allocates, no prefetch
    do_ref("R2 alloc", 16'h0010, 16'd100);
    check("R2 no prefetch on alloc", 32'(pf_valid), 32'd0);
    // R3/R4: initial->transient with new stride 4
    do_ref("R3 init->trans", 16'h0010, 16'd104);
    check("R4 stride learned", 32'(pf_addr), 32'd108);
    drain("R5");
    do_ref("R3 trans->steady", 16'h0010, 16'd108);
    check("R3 steady target", 32'(pf_addr), 32'd112);
    drain("R5");
    // R4: steady miss keeps stride 4
    do_ref("R4 steady->init", 16'h0010, 16'd200);
    check("R4 stride kept", 32'(pf_addr), 32'd204);
    drain("R5");
    do_ref("R3 init->trans", 16'h0010, 16'd300);
    check("R4 stride relearned", 32'(pf_addr), 32'd400);
    drain("R5");
    do_ref("R3 trans->nopred", 16'h0010, 16'd350);
    check("R5 nopred queues nothing", 32'(pf_valid), 32'd0);
    do_ref("R3 nopred->trans", 16'h0010, 16'd400);
    check("R3 nopred recovered", 32'(pf_addr), 32'd450);
    drain("R5");
    do_ref("R3 nopred hold prep", 16'h0010, 16'd900);
    drain("R5");
    // conflicting instruction at same index replaces the entry
    do_ref("R2 conflict", 16'h0014, 16'd40);
    check("R2 conflict no prefetch", 32'(pf_valid), 32'd0);
    do_ref("R2 old pc reallocated", 16'h0010, 16'd950);
    check("R2 realloc no prefetch", 32'(pf_valid), 32'd0);

    // R9 full and R6 order: stride 4 stream with the port held off
    do_ref("R9 fill", 16'h0021, 16'd0);
    for (int k = 1; k <= 6; k++) do_ref("R9 fill", 16'h0021, 16'(4 * k));
    check("R9 full discards", 32'(mq.size()), 32'(DEPTH));
    // R6: head held without ready
    repeat (3) @(negedge clk);
    #1;
    check("R6 head held", 32'(pf_addr), 32'd8);
    // R7: busy suppresses issue and removes nothing
    @(negedge clk); miss_busy = 1'b1; pf_ready = 1'b1;
    #1;
    check("R7 busy blocks valid", 32'(pf_valid), 32'd0);
    @(negedge clk); #1;
    check("R7 head unchanged", 32'(pf_addr), 32'd8);
    // R8: fault drops the head
    miss_busy = 1'b0; pf_fault = 1'b1; pf_ready = 1'b0;
    #1;
    check("R8 fault hides valid", 32'(pf_valid), 32'd0);
    @(posedge clk);
    void'(mq.pop_front());
    @(negedge clk); pf_fault = 1'b0; #1;
    check("R8 next head after drop", 32'(pf_addr), 32'd12);
    drain("R6 order");

    // R9 duplicate: zero stride stream
    do_ref("R9 dup", 16'h0032, 16'd500);
    do_ref("R9 dup", 16'h0032, 16'd500);
    do_ref("R9 dup", 16'h0032, 16'd500);
    check("R9 duplicate dropped", 32'(mq.size()), 32'd1);
    do_ref("R9 dup", 16'h0032, 16'd501);
    drain("R9 dup");

    // sweep over mixed streams with conflicts
    pcs[0] = 16'h0010; pcs[1] = 16'h0011; pcs[2] = 16'h0012;
    pcs[3] = 16'h0013; pcs[4] = 16'h0024; pcs[5] = 16'h0031;
    for (int k = 0; k < 6; k++) begin last[k] = 16'(k * 4000); strd[k] = 16'(k * 8 + 4); end
    strd[5] = 16'hFFF8;
    for (int n = 0; n < 600; n++) begin
      int s;
      lcg = lcg * 32'd1103515245 + 32'd12345;
      s = int'(lcg[18:16]) % 6;
      if (lcg[22:20] == 3'd0) last[s] = last[s] + 16'(lcg[31:24]);
      else last[s] = last[s] + strd[s];
      do_ref("R5 sweep", pcs[s], last[s]);
      drain("R5 sweep");
    end

    report();
    $finish;
  end

endmodule